// File: doc/BRIEF.md
# Low-Power Mode Controller

This controller tracks the operating mode of a small microcontroller and turns that mode into clock-gating and oscillator-enable signals. There are four run modes. NORMAL1 runs on the high-frequency clock only. NORMAL2 runs both oscillators with the high-frequency clock as the system clock. SLOW2 runs both oscillators with the low-frequency clock as the system clock. SLOW1 runs the low-frequency oscillator only. Level inputs mirror the oscillator-enable bits and the system-clock select bit, and the run mode follows them one step per cycle. A halt command enters the idle flavour that matches the current run mode: IDLE1, IDLE2, SLEEP2 or SLEEP1. A wake input returns the controller to the run mode that flavour belongs to.

Two flavours need extra care. SLEEP0 is a deep sleep that can be entered only from SLOW1, and only while the timing-generator halt bit is set. On return, the CPU restarts at once, but the peripheral clock feed waits for a falling edge of the time-base clock. If the time-base timer was enabled at entry, a one-cycle latch-set pulse is produced on return. STOP halts both oscillators. It is left through a release pin, which can be configured as level-sensitive or edge-sensitive, and is followed by a programmable oscillator warm-up. After the warm-up the controller resumes the run mode it left.

Top module: `lp_mode_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the mode is NORMAL1. The gate vector {cpu, wdt, hosc, losc, periph, div} reads 111011 and both interrupt outputs are 0.
- R2: With no command, the run mode moves one step per cycle. NORMAL1 goes to NORMAL2 when losc_on_i=1. NORMAL2 goes to SLOW2 when slow_sel_i=1, otherwise to NORMAL1 when losc_on_i=0. SLOW2 goes to NORMAL2 when slow_sel_i=0, otherwise to SLOW1 when hosc_on_i=0. SLOW1 goes to SLOW2 when hosc_on_i=1. The gate vectors are: NORMAL1 111011, NORMAL2 and SLOW2 111111, SLOW1 110110. The wake input has no effect in run modes.
- R3: Command code 1 (halt) moves NORMAL1 to IDLE1 (gates 001011) and NORMAL2 to IDLE2 (gates 001111). wake_i returns each to the NORMAL mode it came from.
- R4: Command code 1 moves SLOW1 to SLEEP1 (gates 000110) and SLOW2 to SLEEP2 (gates 001110). wake_i returns each to the SLOW mode it came from.
- R5: div_in_en_o is 0 in SLOW1, in every SLEEP flavour, in STOP and during warm-up, and 1 in every other mode.
- R6: Command code 2 enters SLEEP0 (gates 000100) only from SLOW1 with clk_feed_halt_i=1. In any other case the command is ignored.
- R7: wake_i in SLEEP0 returns to SLOW1 with the CPU running and periph_clk_en_o=0. periph_clk_en_o goes to 1 the cycle after a falling edge of tb_clk_i is sampled.
- R8: tb_latch_set_o pulses for exactly the first SLOW1 cycle after SLEEP0 when tb_en_i was 1 at SLEEP0 entry, and stays 0 otherwise. tb_irq_take_o is that pulse ANDed with irq_master_en_i, tb_irq_ie_i and tb_en_i.
- R9: Command code 3 enters STOP from any run mode, with all gates 000000. Commands are ignored in all non-run modes.
- R10: With stop_edge_sel_i=0, STOP is released while stop_pin_i is 1. With stop_edge_sel_i=1, STOP is released only on a 0-to-1 transition of stop_pin_i, and a pin already high has no effect.
- R11: After a release, warm-up lasts 2^(WU_BASE+warmup_sel_i) cycles. During warm-up only the oscillators of the pre-STOP run mode are enabled. After warm-up the controller returns to that run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_cmd_i | input | 2 | Mode command: 0 none, 1 halt, 2 SLEEP0, 3 STOP |
| losc_on_i | input | 1 | Low-frequency oscillator enable bit |
| hosc_on_i | input | 1 | High-frequency oscillator enable bit |
| slow_sel_i | input | 1 | System clock select, 1 = low-frequency |
| clk_feed_halt_i | input | 1 | Timing-generator halt bit, permits SLEEP0 |
| wake_i | input | 1 | Release event for IDLE and SLEEP flavours |
| stop_pin_i | input | 1 | STOP release pin (synchronous) |
| stop_edge_sel_i | input | 1 | 1 = edge-sensitive release, 0 = level |
| warmup_sel_i | input | 2 | Warm-up length exponent offset |
| tb_clk_i | input | 1 | Selected time-base source clock, sampled |
| tb_en_i | input | 1 | Time-base timer enable |
| irq_master_en_i | input | 1 | Interrupt master enable |
| tb_irq_ie_i | input | 1 | Time-base interrupt individual enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| wdt_en_o | output | 1 | Watchdog enable |
| hosc_en_o | output | 1 | High-frequency oscillator enable |
| losc_en_o | output | 1 | Low-frequency oscillator enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| div_in_en_o | output | 1 | Prescaler first-stage input gate |
| tb_latch_set_o | output | 1 | Time-base interrupt latch set pulse |
| tb_irq_take_o | output | 1 | Time-base interrupt serviced |

## Verification
The bench targets the warm-up boundary. It checks the last warm-up cycle and the first run cycle, so an off-by-one counter shows up as a CPU enable that rises one cycle early or late. In edge-sensitive mode the release pin is held high across STOP entry, and a design that treated a held level as an edge would leave STOP at once. After SLEEP0 the time-base clock is toggled only after the return, so a design that restarted the peripheral feed immediately, or on a rising edge, shows a mismatch on periph_clk_en_o. The time-base enable is changed between SLEEP0 entry and return, which exposes a latch-set pulse that samples the enable at the wrong time. Refused SLEEP0 requests (wrong mode, halt bit clear) and commands given while asleep must leave the gates unchanged.

// File: rtl/lp_mode_pkg.sv
package lp_mode_pkg;

  typedef enum logic [3:0] {
    M_NORMAL1, M_NORMAL2, M_SLOW2, M_SLOW1,
    M_IDLE1, M_IDLE2, M_SLEEP1, M_SLEEP2, M_SLEEP0,
    M_STOP, M_WARMUP
  } pmode_e;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_HALT   = 2'd1,
    CMD_SLEEP0 = 2'd2,
    CMD_STOP   = 2'd3
  } pcmd_e;

  typedef struct packed {
    logic cpu;
    logic wdt;
    logic hosc;
    logic losc;
    logic periph;
    logic div;
  } gates_t;

  function automatic logic is_run(pmode_e m);
    return (m == M_NORMAL1) || (m == M_NORMAL2) || (m == M_SLOW2) || (m == M_SLOW1);
  endfunction

endpackage

// File: rtl/lp_wake_detect.sv
module lp_wake_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_pin_i,
  input  logic edge_sel_i,
  input  logic tb_clk_i,
  output logic release_o,
  output logic tb_fall_o
);

  logic pin_q;
  logic tb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      tb_q  <= 1'b0;
    end else begin
      pin_q <= stop_pin_i;
      tb_q  <= tb_clk_i;
    end
  end

  assign release_o = edge_sel_i ? (stop_pin_i & ~pin_q) : stop_pin_i;
  assign tb_fall_o = tb_q & ~tb_clk_i;

endmodule

// File: rtl/lp_warmup_ctr.sv
module lp_warmup_ctr #(
  parameter int unsigned WU_BASE = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] sel_i,
  output logic       done_o
);

  localparam int unsigned CW = WU_BASE + 4;

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [CW-1:0] load_val;

  // 2^n cycles total: load 2^n - 1, done seen while count is zero
  assign load_val = (CW'(1) << (WU_BASE + 32'(sel_i))) - CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= load_val;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign done_o = busy_q && (cnt_q == '0);

  assert_wu_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_q && !done_o));

  assert_wu_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_q || $past(start_i));

endmodule

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
  import lp_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cmd_i,
  input  logic       losc_on_i,
  input  logic       hosc_on_i,
  input  logic       slow_sel_i,
  input  logic       feed_halt_i,
  input  logic       wake_i,
  input  logic       release_i,
  input  logic       wu_done_i,
  input  logic       tb_en_i,
  input  logic       tb_fall_i,
  output pmode_e     mode_o,
  output pmode_e     ret_mode_o,
  output logic       wu_start_o,
  output logic       resume_wait_o,
  output logic       latch_set_o
);

  pmode_e mode_q, mode_d, ret_q;
  pcmd_e  cmd;
  logic   tb_seen_q;
  logic   wait_q;
  logic   latch_q;

  assign cmd = pcmd_e'(cmd_i);

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_NORMAL1: begin
        if      (cmd == CMD_HALT) mode_d = M_IDLE1;
        else if (cmd == CMD_STOP) mode_d = M_STOP;
        else if (losc_on_i)       mode_d = M_NORMAL2;
      end
      M_NORMAL2: begin
        if      (cmd == CMD_HALT) mode_d = M_IDLE2;
        else if (cmd == CMD_STOP) mode_d = M_STOP;
        else if (slow_sel_i)      mode_d = M_SLOW2;
        else if (!losc_on_i)      mode_d = M_NORMAL1;
      end
      M_SLOW2: begin
        if      (cmd == CMD_HALT) mode_d = M_SLEEP2;
        else if (cmd == CMD_STOP) mode_d = M_STOP;
        else if (!slow_sel_i)     mode_d = M_NORMAL2;
        else if (!hosc_on_i)      mode_d = M_SLOW1;
      end
      M_SLOW1: begin
        if      (cmd == CMD_HALT)                  mode_d = M_SLEEP1;
        else if (cmd == CMD_SLEEP0 && feed_halt_i) mode_d = M_SLEEP0;
        else if (cmd == CMD_STOP)                  mode_d = M_STOP;
        else if (hosc_on_i)                        mode_d = M_SLOW2;
      end
      M_IDLE1:  if (wake_i)    mode_d = M_NORMAL1;
      M_IDLE2:  if (wake_i)    mode_d = M_NORMAL2;
      M_SLEEP1: if (wake_i)    mode_d = M_SLOW1;
      M_SLEEP2: if (wake_i)    mode_d = M_SLOW2;
      M_SLEEP0: if (wake_i)    mode_d = M_SLOW1;
      M_STOP:   if (release_i) mode_d = M_WARMUP;
      M_WARMUP: if (wu_done_i) mode_d = ret_q;
      default:                 mode_d = M_NORMAL1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= M_NORMAL1;
      ret_q     <= M_NORMAL1;
      tb_seen_q <= 1'b0;
      wait_q    <= 1'b0;
      latch_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      latch_q <= (mode_q == M_SLEEP0) && wake_i && tb_seen_q;
      if (mode_q != M_STOP && mode_d == M_STOP) ret_q <= mode_q;
      if (mode_q != M_SLEEP0 && mode_d == M_SLEEP0) tb_seen_q <= tb_en_i;
      // peripheral feed resumes only on a time-base falling edge
      if (mode_q == M_SLEEP0 && wake_i)          wait_q <= 1'b1;
      else if (tb_fall_i || mode_q != M_SLOW1)   wait_q <= 1'b0;
    end
  end

  assign mode_o        = mode_q;
  assign ret_mode_o    = ret_q;
  assign wu_start_o    = (mode_q == M_STOP) && release_i;
  assign resume_wait_o = wait_q;
  assign latch_set_o   = latch_q;

  assert_sleep0_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_SLEEP0 && $past(mode_q) != M_SLEEP0)
      |-> ($past(mode_q) == M_SLOW1 && $past(feed_halt_i)));

  assert_sleep0_return_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_SLEEP0 && wake_i) |=> (mode_q == M_SLOW1 && resume_wait_o));

  assert_stop_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_STOP) |=> (mode_q == M_STOP || mode_q == M_WARMUP));

  assert_warm_return_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_WARMUP && $past(mode_q) == M_WARMUP && $past(wu_done_i))
      |-> is_run(mode_q));

endmodule

// File: rtl/lp_gate_dec.sv
module lp_gate_dec
  import lp_mode_pkg::*;
(
  input  pmode_e mode_i,
  input  pmode_e ret_mode_i,
  input  logic   resume_wait_i,
  output gates_t gates_o
);

  // fields: cpu, wdt, hosc, losc, periph, div
  function automatic gates_t base_gates(pmode_e m);
    unique case (m)
      M_NORMAL1: return 6'b111011;
      M_NORMAL2: return 6'b111111;
      M_SLOW2:   return 6'b111111;
      M_SLOW1:   return 6'b110110;
      M_IDLE1:   return 6'b001011;
      M_IDLE2:   return 6'b001111;
      M_SLEEP1:  return 6'b000110;
      M_SLEEP2:  return 6'b001110;
      M_SLEEP0:  return 6'b000100;
      default:   return 6'b000000;
    endcase
  endfunction

  gates_t ret_g;

  always_comb begin
    ret_g   = base_gates(ret_mode_i);
    gates_o = base_gates(mode_i);
    if (mode_i == M_SLOW1 && resume_wait_i) gates_o.periph = 1'b0;
    if (mode_i == M_WARMUP) begin
      gates_o      = '0;
      gates_o.hosc = ret_g.hosc;
      gates_o.losc = ret_g.losc;
    end
  end

endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lp_mode_pkg::*;
#(
  parameter int unsigned WU_BASE = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_cmd_i,
  input  logic       losc_on_i,
  input  logic       hosc_on_i,
  input  logic       slow_sel_i,
  input  logic       clk_feed_halt_i,
  input  logic       wake_i,
  input  logic       stop_pin_i,
  input  logic       stop_edge_sel_i,
  input  logic [1:0] warmup_sel_i,
  input  logic       tb_clk_i,
  input  logic       tb_en_i,
  input  logic       irq_master_en_i,
  input  logic       tb_irq_ie_i,
  output logic       cpu_clk_en_o,
  output logic       wdt_en_o,
  output logic       hosc_en_o,
  output logic       losc_en_o,
  output logic       periph_clk_en_o,
  output logic       div_in_en_o,
  output logic       tb_latch_set_o,
  output logic       tb_irq_take_o
);

  pmode_e mode, ret_mode;
  logic   release_evt, tb_fall, wu_start, wu_done, resume_wait;
  gates_t gates;

  lp_wake_detect u_wake_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_pin_i (stop_pin_i),
    .edge_sel_i (stop_edge_sel_i),
    .tb_clk_i   (tb_clk_i),
    .release_o  (release_evt),
    .tb_fall_o  (tb_fall)
  );

  lp_warmup_ctr #(.WU_BASE(WU_BASE)) u_warmup_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wu_start),
    .sel_i   (warmup_sel_i),
    .done_o  (wu_done)
  );

  lp_mode_fsm u_mode_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_i         (mode_cmd_i),
    .losc_on_i     (losc_on_i),
    .hosc_on_i     (hosc_on_i),
    .slow_sel_i    (slow_sel_i),
    .feed_halt_i   (clk_feed_halt_i),
    .wake_i        (wake_i),
    .release_i     (release_evt),
    .wu_done_i     (wu_done),
    .tb_en_i       (tb_en_i),
    .tb_fall_i     (tb_fall),
    .mode_o        (mode),
    .ret_mode_o    (ret_mode),
    .wu_start_o    (wu_start),
    .resume_wait_o (resume_wait),
    .latch_set_o   (tb_latch_set_o)
  );

  lp_gate_dec u_gate_dec (
    .mode_i        (mode),
    .ret_mode_i    (ret_mode),
    .resume_wait_i (resume_wait),
    .gates_o       (gates)
  );

  assign cpu_clk_en_o    = gates.cpu;
  assign wdt_en_o        = gates.wdt;
  assign hosc_en_o       = gates.hosc;
  assign losc_en_o       = gates.losc;
  assign periph_clk_en_o = gates.periph;
  assign div_in_en_o     = gates.div;
  assign tb_irq_take_o   = tb_latch_set_o & irq_master_en_i & tb_irq_ie_i & tb_en_i;

  assert_edge_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_WARMUP && $past(mode) == M_STOP && stop_edge_sel_i && $past(stop_edge_sel_i))
      |-> ($past(stop_pin_i) && !$past(stop_pin_i, 2)));

  assert_periph_resume_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(periph_clk_en_o) && mode == M_SLOW1 && $past(mode) == M_SLOW1)
      |-> ($past(tb_clk_i, 2) && !$past(tb_clk_i)));

  assert_latch_state_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_latch_set_o |-> (cpu_clk_en_o && !periph_clk_en_o));

  assert_latch_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_latch_set_o |=> !tb_latch_set_o);

endmodule

// File: tb/lp_mode_ctrl_bench.sv
module lp_mode_ctrl_bench;

  localparam int CLK_P   = 10;
  localparam int WU_BASE = 4;
  localparam int NVEC    = 17;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_cmd = 2'd0;
  logic       losc_on = 1'b0, hosc_on = 1'b1, slow_sel = 1'b0, feed_halt = 1'b1;
  logic       wake = 1'b0, stop_pin = 1'b0, edge_sel = 1'b0;
  logic [1:0] wu_sel = 2'd0;
  logic       tb_clk = 1'b0, tb_en = 1'b0, imf = 1'b0, tb_ie = 1'b0;
  logic       cpu_en, wdt_en, hosc_en, losc_en, per_en, div_en, latch_set, irq_take;
  logic [5:0] gates;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // row: cmd[11:10] losc[9] slow[8] hosc[7] wake[6] expected gates[5:0]
  localparam logic [11:0] VEC [NVEC] = '{
    12'b01_0_0_1_0_001011,
    12'b00_0_0_1_0_001011,
    12'b00_0_0_1_1_111011,
    12'b00_1_0_1_0_111111,
    12'b01_1_0_1_0_001111,
    12'b00_1_0_1_1_111111,
    12'b00_1_1_1_0_111111,
    12'b01_1_1_1_0_001110,
    12'b00_1_1_1_1_111111,
    12'b00_1_1_0_0_110110,
    12'b01_1_1_0_0_000110,
    12'b00_1_1_0_0_000110,
    12'b00_1_1_0_1_110110,
    12'b00_1_1_1_0_111111,
    12'b10_1_1_1_0_111111,
    12'b00_1_0_1_0_111111,
    12'b00_0_0_1_0_111011
  };

  always #(CLK_P/2) clk = ~clk;

  lp_mode_ctrl #(.WU_BASE(WU_BASE)) u_lp_mode_ctrl (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .mode_cmd_i      (mode_cmd),
    .losc_on_i       (losc_on),
    .hosc_on_i       (hosc_on),
    .slow_sel_i      (slow_sel),
    .clk_feed_halt_i (feed_halt),
    .wake_i          (wake),
    .stop_pin_i      (stop_pin),
    .stop_edge_sel_i (edge_sel),
    .warmup_sel_i    (wu_sel),
    .tb_clk_i        (tb_clk),
    .tb_en_i         (tb_en),
    .irq_master_en_i (imf),
    .tb_irq_ie_i     (tb_ie),
    .cpu_clk_en_o    (cpu_en),
    .wdt_en_o        (wdt_en),
    .hosc_en_o       (hosc_en),
    .losc_en_o       (losc_en),
    .periph_clk_en_o (per_en),
    .div_in_en_o     (div_en),
    .tb_latch_set_o  (latch_set),
    .tb_irq_take_o   (irq_take)
  );

  assign gates = {cpu_en, wdt_en, hosc_en, losc_en, per_en, div_en};

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(); tick();
    chk("R1 gates in reset", 32'(gates), 32'b111011);
    chk("R1 latch in reset", 32'(latch_set), 32'd0);
    rst_ni = 1'b1;
    tick();
    chk("R1 gates after reset", 32'(gates), 32'b111011);
    chk("R1 take after reset", 32'(irq_take), 32'd0);

    // table walk: R2 R3 R4 R5 run/idle/sleep transitions, R6 refusal from SLOW2
    for (int i = 0; i < NVEC; i++) begin
      mode_cmd = VEC[i][11:10];
      losc_on  = VEC[i][9];
      slow_sel = VEC[i][8];
      hosc_on  = VEC[i][7];
      wake     = VEC[i][6];
      tick();
      chk($sformatf("table row %0d (R2 R3 R4 R5 R6)", i), 32'(gates), 32'(VEC[i][5:0]));
    end
    mode_cmd = 2'd0; wake = 1'b0;

    // R9 STOP entry, commands ignored; R10 level release; R11 warm-up
    mode_cmd = 2'd3; tick();
    chk("R9 stop gates", 32'(gates), 32'b000000);
    mode_cmd = 2'd1; tick();
    chk("R9 halt ignored in stop", 32'(gates), 32'b000000);
    mode_cmd = 2'd0; tick();
    chk("R10 pin low holds stop", 32'(gates), 32'b000000);
    stop_pin = 1'b1; tick();
    chk("R11 warmup from NORMAL1", 32'(gates), 32'b001000);
    for (int i = 0; i < 15; i++) tick();
    chk("R11 last warmup cycle sel0", 32'(gates), 32'b001000);
    tick();
    chk("R11 back to NORMAL1", 32'(gates), 32'b111011);
    stop_pin = 1'b0;

    // to SLOW1
    losc_on = 1'b1; slow_sel = 1'b1; tick(); tick();
    hosc_on = 1'b0; tick();
    chk("R2 reached SLOW1", 32'(gates), 32'b110110);

    // R10 edge mode: held-high pin must not release
    edge_sel = 1'b1; stop_pin = 1'b1; tick();
    mode_cmd = 2'd3; tick();
    chk("R9 stop from SLOW1", 32'(gates), 32'b000000);
    mode_cmd = 2'd0; tick();
    chk("R10 held level ignored in edge mode", 32'(gates), 32'b000000);
    stop_pin = 1'b0; tick();
    chk("R10 low pin holds stop", 32'(gates), 32'b000000);
    wu_sel = 2'd1; stop_pin = 1'b1; tick();
    chk("R11 warmup from SLOW1", 32'(gates), 32'b000100);
    for (int i = 0; i < 31; i++) tick();
    chk("R11 last warmup cycle sel1", 32'(gates), 32'b000100);
    tick();
    chk("R11 back to SLOW1", 32'(gates), 32'b110110);
    stop_pin = 1'b0; edge_sel = 1'b0;

    // R6 refusal with halt bit clear, then SLEEP0 entry
    feed_halt = 1'b0; mode_cmd = 2'd2; tick();
    chk("R6 sleep0 refused without halt bit", 32'(gates), 32'b110110);
    feed_halt = 1'b1; tb_en = 1'b1; tick();
    chk("R6 sleep0 gates", 32'(gates), 32'b000100);
    mode_cmd = 2'd3; tick();
    chk("R9 stop ignored in sleep0", 32'(gates), 32'b000100);
    mode_cmd = 2'd0;
    tb_clk = 1'b1; tick();
    tb_clk = 1'b0; tick();
    chk("R7 edges in sleep0 no effect", 32'(gates), 32'b000100);
    imf = 1'b1; tb_ie = 1'b1; wake = 1'b1; tick();
    chk("R7 return periph held", 32'(gates), 32'b110100);
    chk("R8 latch pulse", 32'(latch_set), 32'd1);
    chk("R8 take with enables", 32'(irq_take), 32'd1);
    wake = 1'b0; tick();
    chk("R8 pulse one cycle", 32'(latch_set), 32'd0);
    chk("R7 still waiting", 32'(gates), 32'b110100);
    tb_clk = 1'b1; tick();
    chk("R7 rising edge no resume", 32'(gates), 32'b110100);
    tb_clk = 1'b0; tick();
    chk("R7 resume after falling edge", 32'(gates), 32'b110110);

    // R8 enable sampled at entry: 0 at entry, 1 at return
    tb_en = 1'b0; mode_cmd = 2'd2; tick();
    mode_cmd = 2'd0; tb_en = 1'b1; wake = 1'b1; tick();
    chk("R8 no pulse when disabled at entry", 32'(latch_set), 32'd0);
    wake = 1'b0;
    tb_clk = 1'b1; tick();
    tb_clk = 1'b0; tick();
    chk("R7 resume second pass", 32'(gates), 32'b110110);

    // R8 pulse with master enable clear
    imf = 1'b0; mode_cmd = 2'd2; tick();
    mode_cmd = 2'd0; wake = 1'b1; tick();
    chk("R8 pulse with master clear", 32'(latch_set), 32'd1);
    chk("R8 no take with master clear", 32'(irq_take), 32'd0);
    wake = 1'b0; tick();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule